// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

The block is a watchdog that runs through four timed stages in a fixed order. Each stage has its own timeout and its own expiry action, so a missed feed can escalate step by step: first nothing or an interrupt, then a processor reset, then a whole-system reset. A prescaler divides the clock into watchdog ticks. The stage counter counts those ticks.

Software reaches the block through a simple word-wide write port and a combinational read port. A key register guards every other register. Stage timeouts, stage actions and the prescale value are first written into shadow copies. They only reach the counting logic when a commit bit is set, so a half-written configuration never drives the counter. A feed write sends the watchdog back to stage 0 with a zeroed counter.

Top module: `staged_watchdog`

## Requirements
- R1: After reset, `irq_o`, `cpu_rst_o` and `sys_rst_o` are low. The lock is closed (key register bit 0 reads 0). The control register reads 0.
- R2: While the lock is closed, any write to an address other than the key register (7) is ignored. Register contents and outputs are unchanged.
- R3: Writing the value `UNLOCK_KEY` to the key register (address 7) opens the lock. Writing any other value, zero included, closes it. Bit 0 of that register reads 1 when the lock is open.
- R4: The control register is at address 0. Bit 0 is the enable, and bits [2:1], [4:3], [6:5] and [8:7] hold the actions of stages 0 to 3. The prescale value is at address 1 and the timeouts of stages 0 to 3 are at addresses 2 to 5. Values written to these registers have no effect on counting until a control write sets bit 9. That bit reads 1 for the one cycle after the write and then 0. The new values are in force from the following cycle.
- R5: With prescale P (0 is treated as 1), a tick occurs every P clocks. A stage with timeout T expires at the T-th tick after it was entered or after the counter was enabled.
- R6: On expiry the counter restarts from zero and the stage advances 0→1→2→3. Expiry of stage 3 returns to stage 0.
- R7: The action codes are 0 for none, 1 for interrupt, 2 for a `cpu_rst_o` pulse and 3 for a `sys_rst_o` pulse. Each pulse lasts exactly `PULSE_W` clocks, starting in the cycle after the expiry edge.
- R8: An interrupt action sets a raw flag, which reads as bit 0 at address 9. `irq_o` equals the raw flag ANDed with the interrupt enable (address 8, bit 0). Writing bit 0 at address 10 clears the flag. If a clear and a new expiry fall in the same cycle, the flag stays set.
- R9: Any write to address 6 while unlocked is a feed. It returns the watchdog to stage 0 with a zeroed counter and prescaler, and it takes priority over an expiry in the same cycle.
- R10: Control bit 0 reads back the running state. Clearing it stops counting and zeroes the stage, counter and prescaler, so no action fires while the watchdog is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 1 | Level interrupt |
| cpu_rst_o | output | 1 | Processor reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The interesting collision is an interrupt clear written in the very cycle when a later stage expires with an interrupt action. The bench counts clock edges from the enable write, so it knows that edge exactly, and it times the clear write to land on it. The raw flag must still read 1 afterwards. A second clear, one cycle later, must then drop it. The tests also cover feeding mid-stage and the escalation across all four stages with the wrap back to stage 0, each compared cycle by cycle against a schedule computed from the timeouts.

// File: rtl/staged_watchdog.sv
module staged_watchdog #(
  parameter int          DW          = 32,
  parameter int          AW          = 4,
  parameter int          PW          = 16,
  parameter int          PULSE_W     = 4,
  parameter logic [31:0] UNLOCK_KEY  = 32'h5A5A_C3E1,
  parameter logic [31:0] DEF_TIMEOUT = 32'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq_o,
  output logic          cpu_rst_o,
  output logic          sys_rst_o
);
  localparam logic [AW-1:0] A_CTRL = 0, A_PRE = 1, A_TO0 = 2, A_FEED = 6,
                            A_KEY = 7, A_IEN = 8, A_IRAW = 9, A_ICLR = 10;
  localparam int PCW = $clog2(PULSE_W + 1);

  logic          unlocked, en_q, upd_q, ien_q, iraw_q;
  logic [7:0]    sh_act, ac_act;
  logic [PW-1:0] sh_pre, ac_pre, pcnt;
  logic [DW-1:0] sh_to [4];
  logic [DW-1:0] ac_to [4];
  logic [DW-1:0] cnt;
  logic [1:0]    stage, cur_act;
  logic [PCW-1:0] cpu_cnt, sys_cnt;

  logic we, feed, stop, tick, fire;
  logic [PW-1:0] pre_last;

  assign we       = wr_en && unlocked;
  assign feed     = we && wr_addr == A_FEED;
  assign stop     = !en_q || (we && wr_addr == A_CTRL && !wr_data[0]);
  assign pre_last = (ac_pre == '0) ? '0 : ac_pre - 1'b1;
  assign tick     = !stop && !feed && pcnt == pre_last;
  assign cur_act  = ac_act[2*stage +: 2];
  assign fire     = tick && ({1'b0, cnt} + 1'b1 >= {1'b0, ac_to[stage]});

  assign irq_o     = iraw_q && ien_q;
  assign cpu_rst_o = cpu_cnt != '0;
  assign sys_rst_o = sys_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0; en_q <= 1'b0; upd_q <= 1'b0; ien_q <= 1'b0;
      iraw_q <= 1'b0; sh_act <= '0; ac_act <= '0;
      sh_pre <= PW'(1); ac_pre <= PW'(1); pcnt <= '0;
      cnt <= '0; stage <= '0; cpu_cnt <= '0; sys_cnt <= '0;
      for (int i = 0; i < 4; i++) begin
        sh_to[i] <= DEF_TIMEOUT;
        ac_to[i] <= DEF_TIMEOUT;
      end
    end else begin
      upd_q <= 1'b0;
      if (wr_en && wr_addr == A_KEY) unlocked <= (wr_data == UNLOCK_KEY);
      if (we) begin
        case (wr_addr)
          A_CTRL: begin en_q <= wr_data[0]; sh_act <= wr_data[8:1]; upd_q <= wr_data[9]; end
          A_PRE:  sh_pre <= wr_data[PW-1:0];
          A_IEN:  ien_q <= wr_data[0];
          default: ;
        endcase
        for (int i = 0; i < 4; i++)
          if (wr_addr == A_TO0 + AW'(i)) sh_to[i] <= wr_data;
      end
      if (upd_q) begin
        ac_act <= sh_act;
        ac_pre <= sh_pre;
        for (int i = 0; i < 4; i++) ac_to[i] <= sh_to[i];
      end
      if (stop || feed) begin
        pcnt <= '0; cnt <= '0; stage <= '0;
      end else if (tick) begin
        pcnt <= '0;
        if (fire) begin
          cnt   <= '0;
          stage <= stage + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
      if (fire && cur_act == 2'd1) iraw_q <= 1'b1;
      else if (we && wr_addr == A_ICLR && wr_data[0]) iraw_q <= 1'b0;
      if (fire && cur_act == 2'd2) cpu_cnt <= PCW'(PULSE_W);
      else if (cpu_cnt != '0) cpu_cnt <= cpu_cnt - 1'b1;
      if (fire && cur_act == 2'd3) sys_cnt <= PCW'(PULSE_W);
      else if (sys_cnt != '0) sys_cnt <= sys_cnt - 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[9:0] = {upd_q, sh_act, en_q};
      A_PRE:  rd_data[PW-1:0] = sh_pre;
      A_KEY:  rd_data[0] = unlocked;
      A_IEN:  rd_data[0] = ien_q;
      A_IRAW: rd_data[0] = iraw_q;
      default: if (rd_addr >= A_TO0 && rd_addr < A_FEED) rd_data = sh_to[rd_addr - A_TO0];
    endcase
  end

  p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_addr == A_CTRL) |=> $stable(en_q) && $stable(sh_act));
  p_commit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !(wr_en && wr_addr == A_CTRL)) |=> !upd_q);
  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |=> cpu_rst_o);
  p_feed_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (cnt == '0 && stage == '0));
  p_stopped_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (cnt == '0 && stage == '0));
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ien_q);
endmodule

// File: tb/staged_watchdog_tb.sv
module staged_watchdog_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [31:0] KEY = 32'h5A5A_C3E1;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq_o, cpu_rst_o, sys_rst_o;
  int checks = 0, fails = 0;
  bit done = 0;

  staged_watchdog dut_i (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
                         .rd_data, .irq_o, .cpu_rst_o, .sys_rst_o);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic logic [31:0] ctl(bit en, bit commit, logic [1:0] a0, a1, a2, a3);
    return {22'b0, commit, a3, a2, a1, a0, en};
  endfunction

  task automatic setup(int p, int t0, int t1, int t2, int t3, logic [1:0] a0, a1, a2, a3);
    wr(7, KEY);
    wr(0, 0);
    wr(10, 1);
    wr(1, p); wr(2, t0); wr(3, t1); wr(4, t2); wr(5, t3);
    wr(8, 1);
    wr(0, ctl(0, 1, a0, a1, a2, a3));
    wr(0, ctl(1, 0, a0, a1, a2, a3));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", irq_o, 0); chk("R1 cpu", cpu_rst_o, 0); chk("R1 sys", sys_rst_o, 0);
    rd(7, d); chk("R1 lock", d, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(0, ctl(1, 0, 1, 1, 1, 1));
    rd(0, d); chk("R2 ctrl ignored", d, 0);
    wr(7, KEY); rd(7, d); chk("R3 unlocked", d, 1);
    wr(7, 0); rd(7, d); chk("R3 relocked", d, 0);
    wr(2, 5); rd(2, d); chk("R2 timeout ignored", d, 1000);
  endtask

  task automatic t_staged();
    logic [31:0] d;
    wr(7, KEY); wr(2, 2); wr(8, 1);
    wr(0, ctl(1, 0, 1, 0, 0, 0));
    rd(0, d); chk("R10 running readback", d[0], 1);
    repeat (10) @(negedge clk);
    chk("R4 uncommitted no effect", irq_o, 0);
    wr(0, ctl(1, 1, 1, 0, 0, 0));
    rd(0, d); chk("R4 commit bit set", d[9], 1);
    @(negedge clk);
    rd(0, d); chk("R4 commit bit cleared", d[9], 0);
    chk("R4 not yet", irq_o, 0);
    @(negedge clk);
    chk("R4 committed timeout in force", irq_o, 1);
  endtask

  task automatic t_sequence();
    setup(1, 3, 2, 4, 2, 0, 2, 3, 1);
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      chk("R6/R7 cpu pulse", cpu_rst_o, (n >= 5 && n <= 8) || (n >= 16 && n <= 19));
      chk("R6/R7 sys pulse", sys_rst_o, (n >= 9 && n <= 12) || n == 20);
      chk("R6/R7 irq", irq_o, n >= 11);
    end
  endtask

  task automatic t_prescale();
    setup(3, 2, 100, 100, 100, 1, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk("R5 before 6 clocks", irq_o, 0);
    @(negedge clk);
    chk("R5 at P*T", irq_o, 1);
  endtask

  task automatic t_feed();
    setup(1, 6, 100, 100, 100, 1, 0, 0, 0);
    repeat (4) @(negedge clk);
    wr(6, 0);
    repeat (5) @(negedge clk);
    chk("R9 restarted from zero", irq_o, 0);
    @(negedge clk);
    chk("R9 expiry after feed", irq_o, 1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    setup(1, 4, 4, 4, 4, 1, 1, 1, 1);
    repeat (4) @(negedge clk);
    chk("R8 first expiry", irq_o, 1);
    repeat (3) @(negedge clk);
    wr(10, 1);
    rd(9, d); chk("R8 set wins over clear", d, 1);
    wr(10, 1);
    rd(9, d); chk("R8 clear", d, 0);
    chk("R8 irq low after clear", irq_o, 0);
    wr(8, 0);
    repeat (2) @(negedge clk);
    rd(9, d); chk("R8 raw set while gated", d, 1);
    chk("R8 irq gated", irq_o, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    setup(1, 3, 3, 3, 3, 1, 1, 1, 1);
    wr(0, ctl(0, 0, 1, 1, 1, 1));
    rd(0, d); chk("R10 stopped readback", d[0], 0);
    repeat (10) @(negedge clk);
    chk("R10 no action when stopped", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_staged();
    t_sequence();
    t_prescale();
    t_feed();
    t_collide();
    t_stop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule